// File: doc/BRIEF.md
# Four-Lane Pixel Serialiser with Forwarded Clock Lane

This block takes a 28-bit pixel word (24 colour bits plus line sync, frame sync and data-enable) once per pixel clock and sends it out as four serial data lanes. Each lane carries seven bits per pixel clock, so it runs at seven times the pixel rate. A fifth lane sends a fixed seven-bit clock pattern whose first bit lines up with the first bit of every data word. A receiver can use this lane to recover word framing and a sampling clock.

The bit clock, at seven times the pixel rate and phase-related to the pixel clock, comes from outside. The pixel word can be sampled on either pixel-clock edge, chosen by a select input. A build parameter can fix sampling to the falling edge. A power-down input forces every lane low and clears the captured data.

The captured word crosses into the bit-clock domain through a holding register. The word boundary is found by sampling the pixel clock in the bit-clock domain.

Top module: `pixlane_tx`

## Requirements
- R1: One word is loaded into the lane shifters every seven bit clocks. The load happens on the second bit-clock rising edge after the pixel clock goes high.
- R2: Input bits 7L to 7L+6 are sent on data lane L, for L = 0 to 3.
- R3: Each data lane sends its seven bits most significant first, one bit per bit clock.
- R4: The clock lane repeats the pattern 1,1,0,0,0,1,1 (first bit sent first). Its first bit occupies the same bit slot as the first bit of each data word.
- R5: With edgeSel = 1, the word is sampled on the pixel-clock rising edge. A word sampled on the rising edge of pixel cycle n starts in the word slot that begins in pixel cycle n+1.
- R6: With edgeSel = 0, the word is sampled on the pixel-clock falling edge. A word sampled on the falling edge of pixel cycle n starts in the word slot that begins in pixel cycle n+2.
- R7: When EDGE_SELECTABLE = 0, edgeSel has no effect and the block always behaves as in R6.
- R8: While pwrDown is high, all four data lanes and the clock lane are low, starting from the first bit-clock rising edge after pwrDown goes high. No word load takes place during this time.
- R9: Power-down clears the captured data. After pwrDown is released, all lanes stay low until the first load. The first word slot then carries all zeros on the data lanes while the clock lane runs its pattern. With edgeSel = 1, the word sampled on the first pixel rising edge after release follows in the next slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pixClk | input | 1 | Pixel clock |
| bitClk | input | 1 | Bit clock, seven times the pixel rate and phase-related to pixClk |
| edgeSel | input | 1 | 1: sample on the pixel rising edge; 0: sample on the falling edge |
| pwrDown | input | 1 | High forces all lanes low and clears the captured word |
| pixData | input | 28 | Pixel word: colour bits plus line sync, frame sync and data-enable |
| dataLane | output | 4 | Serial data lanes, one bit per bit clock each |
| clkLane | output | 1 | Forwarded clock pattern lane |

## Verification
Every output comes from a register clocked by bitClk. A word slot opens on the second bit-clock edge after the pixel clock rises. A rising-edge sample reaches the lanes one pixel period after it is taken. A falling-edge sample first reaches the lanes in the slot that opens in the second pixel cycle after the one in which it was taken. The bench keeps its own bit-phase and pixel-cycle counters and samples on the falling bit-clock edge. For each bit slot it derives which earlier pixel cycle's word must be showing and which bit index of it. It also waits four pixel cycles after any change of edge select or power-down before comparing the stream, because the two-register handoff is still flushing during that time. The power-down cases are checked one bit clock after the control changes.

// File: rtl/pixlane_pkg.sv
package pixlane_pkg;
  localparam int DEF_LANE_BITS = 7;
  localparam int DEF_DATA_LANES = 4;
  localparam logic [DEF_LANE_BITS-1:0] DEF_CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic load;
    logic clear;
  } txStrobe_t;
endpackage

// File: rtl/pixlane_serializer.sv
module pixlane_serializer #(
  parameter int WIDTH = 7
) (
  input  logic             bitClk,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] loadVal,
  output logic             serOut
);
  logic [WIDTH-1:0] shreg;

  always_ff @(posedge bitClk) begin
    if (clear) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= loadVal;
    end else begin
      shreg <= {shreg[WIDTH-2:0], 1'b0};
    end
  end

  // Most significant bit leaves first; output is a flop bit.
  assign serOut = shreg[WIDTH-1];
endmodule

// File: rtl/pixlane_ctrl.sv
module pixlane_ctrl
  import pixlane_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       bitClk,
  input  logic       pixClk,
  input  logic       pwrDown,
  output txStrobe_t  strb
);
  logic [SYNC_STAGES-1:0] pixSync;
  logic                   pixRise;

  // Pixel clock sampled as data in the bit-clock domain.
  always_ff @(posedge bitClk) begin
    pixSync <= {pixSync[SYNC_STAGES-2:0], pixClk};
  end

  assign pixRise = pixSync[SYNC_STAGES-2] & ~pixSync[SYNC_STAGES-1];

  always_comb begin
    strb.clear = pwrDown;
    strb.load  = pixRise & ~pwrDown;
  end
endmodule

// File: rtl/pixlane_datapath.sv
module pixlane_datapath
  import pixlane_pkg::*;
#(
  parameter int LANE_BITS = DEF_LANE_BITS,
  parameter int DATA_LANES = DEF_DATA_LANES,
  parameter int EDGE_SELECTABLE = 1,
  parameter logic [LANE_BITS-1:0] CLK_PATTERN = DEF_CLK_PATTERN
) (
  input  logic                            pixClk,
  input  logic                            bitClk,
  input  logic                            pwrDown,
  input  logic                            edgeSel,
  input  logic [LANE_BITS*DATA_LANES-1:0] pixData,
  input  txStrobe_t                       strb,
  output logic [DATA_LANES-1:0]           dataLane,
  output logic                            clkLane
);
  localparam int WORD_BITS = LANE_BITS * DATA_LANES;

  logic [WORD_BITS-1:0] capFall;
  logic [WORD_BITS-1:0] pickWord;
  logic [WORD_BITS-1:0] holdWord;

  // Falling-edge capture exists in every variant.
  always_ff @(negedge pixClk) begin
    capFall <= pwrDown ? '0 : pixData;
  end

  generate
    if (EDGE_SELECTABLE != 0) begin : g_sel
      logic [WORD_BITS-1:0] capRise;
      always_ff @(posedge pixClk) begin
        capRise <= pwrDown ? '0 : pixData;
      end
      assign pickWord = edgeSel ? capRise : capFall;
    end else begin : g_fixed
      logic unusedSel;
      assign unusedSel = edgeSel;
      assign pickWord  = capFall;
    end
  endgenerate

  // First stage of the domain handoff: whole word held per slot.
  always_ff @(posedge bitClk) begin
    if (strb.clear) begin
      holdWord <= '0;
    end else if (strb.load) begin
      holdWord <= pickWord;
    end
  end

  // Second stage: one shifter per data lane.
  generate
    for (genvar g = 0; g < DATA_LANES; g++) begin : g_lane
      pixlane_serializer #(.WIDTH(LANE_BITS)) u_ser (
        .bitClk (bitClk),
        .clear  (strb.clear),
        .load   (strb.load),
        .loadVal(holdWord[g*LANE_BITS +: LANE_BITS]),
        .serOut (dataLane[g])
      );
    end
  endgenerate

  pixlane_serializer #(.WIDTH(LANE_BITS)) u_clkSer (
    .bitClk (bitClk),
    .clear  (strb.clear),
    .load   (strb.load),
    .loadVal(CLK_PATTERN),
    .serOut (clkLane)
  );
endmodule

// File: rtl/pixlane_tx.sv
module pixlane_tx
  import pixlane_pkg::*;
#(
  parameter int LANE_BITS = DEF_LANE_BITS,
  parameter int DATA_LANES = DEF_DATA_LANES,
  parameter int EDGE_SELECTABLE = 1,
  parameter int SYNC_STAGES = 2,
  parameter logic [LANE_BITS-1:0] CLK_PATTERN = DEF_CLK_PATTERN
) (
  input  logic                            pixClk,
  input  logic                            bitClk,
  input  logic                            edgeSel,
  input  logic                            pwrDown,
  input  logic [LANE_BITS*DATA_LANES-1:0] pixData,
  output logic [DATA_LANES-1:0]           dataLane,
  output logic                            clkLane
);
  txStrobe_t strb;

  pixlane_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .bitClk (bitClk),
    .pixClk (pixClk),
    .pwrDown(pwrDown),
    .strb   (strb)
  );

  pixlane_datapath #(
    .LANE_BITS      (LANE_BITS),
    .DATA_LANES     (DATA_LANES),
    .EDGE_SELECTABLE(EDGE_SELECTABLE),
    .CLK_PATTERN    (CLK_PATTERN)
  ) u_dp (
    .pixClk  (pixClk),
    .bitClk  (bitClk),
    .pwrDown (pwrDown),
    .edgeSel (edgeSel),
    .pixData (pixData),
    .strb    (strb),
    .dataLane(dataLane),
    .clkLane (clkLane)
  );
endmodule

// File: rtl/pixlane_tx_chk.sv
module pixlane_tx_chk
  import pixlane_pkg::*;
#(
  parameter int LANE_BITS = DEF_LANE_BITS,
  parameter int DATA_LANES = DEF_DATA_LANES,
  parameter logic [LANE_BITS-1:0] CLK_PATTERN = DEF_CLK_PATTERN
) (
  input logic                  bitClk,
  input logic                  pwrDown,
  input txStrobe_t             strb,
  input logic [DATA_LANES-1:0] dataLane,
  input logic                  clkLane
);
  localparam int POS_W = $clog2(LANE_BITS);

  logic             started  = 1'b0;
  logic             seenLoad = 1'b0;
  logic             freshPd  = 1'b0;
  logic [POS_W-1:0] pos      = '0;

  always_ff @(posedge bitClk) begin
    started <= 1'b1;
    if (pwrDown) begin
      seenLoad <= 1'b0;
      freshPd  <= 1'b1;
      pos      <= '0;
    end else if (strb.load) begin
      seenLoad <= 1'b1;
      freshPd  <= 1'b0;
      pos      <= '0;
    end else if (pos != POS_W'(LANE_BITS-1)) begin
      pos <= pos + 1'b1;
    end
  end

  // R1: loads are spaced one full word apart
  a_r1_load_period: assert property (@(posedge bitClk) disable iff (!started || pwrDown)
    (strb.load && seenLoad) |-> (pos == POS_W'(LANE_BITS-1)));

  // R4: clock lane follows its pattern from the slot start
  a_r4_clock_pattern: assert property (@(posedge bitClk) disable iff (!started || pwrDown)
    seenLoad |-> (clkLane == CLK_PATTERN[LANE_BITS-1-int'(pos)]));

  // R8: lanes low one edge into power-down
  a_r8_lanes_low: assert property (@(posedge bitClk) disable iff (!started)
    pwrDown |=> (dataLane == '0 && !clkLane));

  // R8: no load while powered down
  a_r8_no_load: assert property (@(posedge bitClk) disable iff (!started)
    pwrDown |-> !strb.load);

  // R9: first slot after power-down carries zeros
  a_r9_first_zero: assert property (@(posedge bitClk) disable iff (!started || pwrDown)
    (strb.load && freshPd) |=> (dataLane == '0));
endmodule

bind pixlane_tx pixlane_tx_chk #(
  .LANE_BITS  (LANE_BITS),
  .DATA_LANES (DATA_LANES),
  .CLK_PATTERN(CLK_PATTERN)
) u_chk (
  .bitClk  (bitClk),
  .pwrDown (pwrDown),
  .strb    (strb),
  .dataLane(dataLane),
  .clkLane (clkLane)
);

// File: tb/pixlane_tx_tb.sv
module pixlane_tx_tb;
  import pixlane_pkg::*;

  localparam int LB = DEF_LANE_BITS;
  localparam int NL = DEF_DATA_LANES;
  localparam int WB = LB * NL;
  localparam logic [LB-1:0] PAT = 7'b1100011;  // R4 pattern
  localparam int NVEC = 8;
  // Stimulus as expected per-lane codes: [vector][lane]; word built by R2 mapping.
  localparam logic [LB-1:0] VEC_LANE [NVEC][NL] = '{
    '{7'h00, 7'h00, 7'h00, 7'h00},
    '{7'h7F, 7'h7F, 7'h7F, 7'h7F},
    '{7'h40, 7'h00, 7'h00, 7'h01},
    '{7'h55, 7'h2A, 7'h55, 7'h2A},
    '{7'h01, 7'h02, 7'h04, 7'h08},
    '{7'h7F, 7'h00, 7'h7F, 7'h00},
    '{7'h1E, 7'h63, 7'h0C, 7'h70},
    '{7'h00, 7'h7F, 7'h00, 7'h40}
  };

  logic          bitClk = 1'b0;
  logic          pixClk = 1'b0;
  logic          edgeSel;
  logic          pwrDown;
  logic [WB-1:0] dataIn;
  logic [NL-1:0] dLaneA, dLaneB;
  logic          cLaneA, cLaneB;

  int phase = 0;
  int cycNo = 0;
  int curIdx = 1;
  int hist [0:1023];
  int settleA = 0, settleB = 0;
  logic lastSel = 1'b1;
  logic monOn = 1'b0;
  logic done = 1'b0;
  int total = 0, bad = 0;

  pixlane_tx u_dut (
    .pixClk(pixClk), .bitClk(bitClk), .edgeSel(edgeSel), .pwrDown(pwrDown),
    .pixData(dataIn), .dataLane(dLaneA), .clkLane(cLaneA)
  );

  pixlane_tx #(.EDGE_SELECTABLE(0)) u_fixed (
    .pixClk(pixClk), .bitClk(bitClk), .edgeSel(1'b1), .pwrDown(pwrDown),
    .pixData(dataIn), .dataLane(dLaneB), .clkLane(cLaneB)
  );

  initial forever #4 bitClk = ~bitClk;

  // Pixel clock: high for bit phases 0..3, low for 4..6.
  always @(posedge bitClk) begin
    phase  <= (phase == LB-1) ? 0 : phase + 1;
    pixClk <= (phase == LB-1) || (phase < 3);
    if (phase == LB-1) begin
      cycNo <= cycNo + 1;
      hist[cycNo+1] <= curIdx;
    end
    if (pwrDown || edgeSel != lastSel) settleA <= 0;
    else if (phase == LB-1 && settleA < 15) settleA <= settleA + 1;
    if (pwrDown) settleB <= 0;
    else if (phase == LB-1 && settleB < 15) settleB <= settleB + 1;
    lastSel <= edgeSel;
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (cycle %0d phase %0d)", tag, act, exp, cycNo, phase);
    end
  endtask

  function automatic logic [WB-1:0] buildWord(input int idx);
    logic [WB-1:0] w;
    for (int l = 0; l < NL; l++) w[l*LB +: LB] = VEC_LANE[idx][l];
    return w;
  endfunction

  task automatic waitPhase(input int p);
    do @(negedge bitClk); while (phase != p);
  endtask

  task automatic driveVec(input int idx);
    waitPhase(5);
    dataIn = buildWord(idx);
    curIdx = idx;
  endtask

  // Stream monitor: which earlier word and which bit index must be showing.
  always @(negedge bitClk) begin
    int startC, bi, src;
    logic [NL-1:0] expD;
    logic expC;
    if (monOn) begin
      startC = (phase >= 2) ? cycNo : cycNo - 1;
      bi     = (phase >= 2) ? phase - 2 : phase + LB - 2;
      expC   = PAT[LB-1-bi];
      if (settleA >= 4) begin
        src = startC - (edgeSel ? 1 : 2);
        if (src >= 0 && hist[src] >= 0) begin
          for (int l = 0; l < NL; l++) expD[l] = VEC_LANE[hist[src]][l][LB-1-bi];
          chk(dLaneA == expD, edgeSel ? "R1 R2 R3 R5 data" : "R1 R2 R3 R6 data",
              8'(dLaneA), 8'(expD));
          chk(cLaneA == expC, "R4 clock lane", 8'(cLaneA), 8'(expC));
        end
      end
      if (settleB >= 4) begin
        src = startC - 2;
        if (src >= 0 && hist[src] >= 0) begin
          for (int l = 0; l < NL; l++) expD[l] = VEC_LANE[hist[src]][l][LB-1-bi];
          chk(dLaneB == expD, "R7 fixed falling data", 8'(dLaneB), 8'(expD));
          chk(cLaneB == expC, "R7 R4 fixed clock", 8'(cLaneB), 8'(expC));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) hist[i] = -1;
    pwrDown = 1'b1;
    edgeSel = 1'b1;
    dataIn  = buildWord(1);
    curIdx  = 1;

    // R8: reset / power-down state, data held at all ones
    repeat (20) @(negedge bitClk);
    for (int k = 0; k < LB; k++) begin
      chk(dLaneA == '0 && !cLaneA && dLaneB == '0 && !cLaneB, "R8 lanes low in power-down",
          {2'b0, cLaneB, dLaneB[0], dLaneA}, 8'h00);
      @(negedge bitClk);
    end

    // R9: release, then idle lanes, then one zero word with the clock pattern
    waitPhase(5);
    pwrDown = 1'b0;
    waitPhase(0);
    chk(dLaneA == '0 && !cLaneA, "R9 low before first load", {3'b0, cLaneA, dLaneA}, 8'h00);
    waitPhase(1);
    chk(dLaneA == '0 && !cLaneA, "R9 low before first load", {3'b0, cLaneA, dLaneA}, 8'h00);
    for (int k = 0; k < LB; k++) begin
      @(negedge bitClk);
      chk(dLaneA == '0 && dLaneB == '0, "R9 first word cleared", {dLaneB, dLaneA}, 8'h00);
      chk(cLaneA == PAT[LB-1-k], "R4 R1 clock lane slot after release", 8'(cLaneA), 8'(PAT[LB-1-k]));
    end
    @(negedge bitClk);
    chk(dLaneA == '1 && cLaneA, "R9 R5 first sampled word follows", {3'b0, cLaneA, dLaneA}, 8'h1F);

    // Table walk, rising-edge sampling (R5), fixed variant in parallel (R7)
    monOn = 1'b1;
    repeat (4) waitPhase(5);
    for (int i = 0; i < NVEC; i++) driveVec(i);
    for (int i = NVEC - 1; i >= 0; i--) driveVec(i);
    repeat (3) waitPhase(5);

    // Switch to falling-edge sampling (R6)
    waitPhase(5);
    edgeSel = 1'b0;
    repeat (4) waitPhase(5);
    for (int i = 0; i < NVEC; i++) driveVec(i);
    for (int i = 0; i < NVEC; i++) driveVec((i * 3) % NVEC);
    repeat (3) waitPhase(5);
    monOn = 1'b0;

    // R8: power-down in mid-word
    waitPhase(3);
    pwrDown = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge bitClk);
      chk(dLaneA == '0 && !cLaneA && dLaneB == '0 && !cLaneB, "R8 lanes low mid-run",
          {2'b0, cLaneB, dLaneB[0], dLaneA}, 8'h00);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule